// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned N-bit operands with no clock and returns their 2N-bit product. N is a parameter and defaults to 4. The product is built one column of weight at a time, giving 2N-1 column steps. Column k collects every single-bit product a[i]&b[j] with i+j equal to k. It adds them together with the carry that arrives from column k-1. The low bit of that sum becomes product bit k, and all the sum's upper bits pass on whole as a carry of several bits into column k+1. The carry that leaves the last column drives the top product bit.

All bit products and all column sums are formed at the same time in one combinational cone, so a new operand pair produces its product within the same cycle. A surrounding pipeline can register the result where its timing needs it. Every column adder uses one common sum width. That width is derived from N so that the bit-product count plus the largest carry that can arrive always fits.

Top module: `vc_column_mul`

## Requirements
- R1: For every operand pair, p equals the unsigned product a*b, zero-extended to 2N bits.
- R2: Product bit 0 equals a[0]&b[0].
- R3: Product bit 1 equals the exclusive-or of a[1]&b[0] and a[0]&b[1], because column 0 never produces a carry.
- R4: The carry leaving the last column (weight 2N-2) is at most 1 and drives p[2N-1]; with both operands all ones and N of 2 or more, p[2N-1] is 1.
- R5: If either operand is zero, p is zero.
- R6: If b is 1, p equals a zero-extended; swapping a and b leaves p unchanged.
- R7: No column overflows: the carry into column 0 is zero and the carry into any other column is at most N-1.
- R8: p is a purely combinational function of a and b and settles without any clock edge.
- R9: With N set to 8, p still equals a*b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| p | output | 2N | Unsigned product a*b |

## Verification
At N=4 every one of the 256 operand pairs is applied and compared with the arithmetic product. This exposes any wrong term in a column, a dropped carry bit, or a column adder that is too narrow. Directed pairs isolate the cases that a wide sweep can hide. All-ones operands push the largest carry through every column and set the top bit. Zero operands and a multiplier of one expose stray terms, and swapped operands expose an asymmetric mapping of bits to columns. A random sweep on an N=8 instance shows that the derived widths and the generated column structure hold for a larger parameter.

// File: rtl/vc_mul_pkg.sv
package vc_mul_pkg;

  // Width of one column sum. A column has at most n bit products, and the
  // incoming carry is at most n-1, so the sum stays below 2n.
  function automatic int col_sum_w(input int n);
    return $clog2(2 * n) + 1;
  endfunction

  // Number of column steps for an n x n product
  function automatic int col_steps(input int n);
    return 2 * n - 1;
  endfunction

endpackage

// File: rtl/vc_pp_gen.sv
// Forms the bit products that belong to column K. Slot i carries a[i]&b[K-i]
// when that b index exists; all other slots are tied to zero.
module vc_pp_gen #(
  parameter int N = 4,
  parameter int K = 0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] terms
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if ((K - i) >= 0 && (K - i) < N) begin : g_live
      assign terms[i] = a[i] & b[K-i];
    end else begin : g_dead
      assign terms[i] = 1'b0;
    end
  end

endmodule

// File: rtl/vc_col_sum.sv
// Adds the bit products of one column to the incoming carry, then splits the
// sum into the result bit (its LSB) and the carry for the next column.
module vc_col_sum #(
  parameter int N     = 4,
  parameter int SUM_W = 4,
  localparam int CW   = SUM_W - 1
) (
  input  logic [N-1:0]  terms,
  input  logic [CW-1:0] carry_in,
  output logic          res_bit,
  output logic [CW-1:0] carry_out
);

  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = {1'b0, carry_in};
    for (int i = 0; i < N; i++) begin
      acc = acc + {{(SUM_W-1){1'b0}}, terms[i]};
    end
  end

  assign res_bit   = acc[0];
  assign carry_out = acc[SUM_W-1:1];

endmodule

// File: rtl/vc_column_mul.sv
module vc_column_mul #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);

  localparam int SUM_W = vc_mul_pkg::col_sum_w(N);
  localparam int CW    = SUM_W - 1;
  localparam int STEPS = vc_mul_pkg::col_steps(N);

  // Slice k holds the carry entering column k; slice STEPS leaves the last one.
  logic [(STEPS+1)*CW-1:0] carry_flat;

  assign carry_flat[CW-1:0] = '0;

  for (genvar k = 0; k < STEPS; k++) begin : g_col
    logic [N-1:0] terms;

    vc_pp_gen #(
      .N (N),
      .K (k)
    ) u_pp (
      .a     (a),
      .b     (b),
      .terms (terms)
    );

    vc_col_sum #(
      .N     (N),
      .SUM_W (SUM_W)
    ) u_sum (
      .terms     (terms),
      .carry_in  (carry_flat[k*CW +: CW]),
      .res_bit   (p[k]),
      .carry_out (carry_flat[(k+1)*CW +: CW])
    );
  end

  // The final carry is at most 1 (upper bits are provably zero), so the
  // reduction OR equals its LSB and keeps every carry bit in use.
  assign p[2*N-1] = |carry_flat[STEPS*CW +: CW];

endmodule

// File: rtl/vc_column_mul_chk.sv
module vc_column_mul_chk #(
  parameter int N = 4,
  localparam int CW    = vc_mul_pkg::col_sum_w(N) - 1,
  localparam int STEPS = vc_mul_pkg::col_steps(N)
) (
  input logic [N-1:0]              a,
  input logic [N-1:0]              b,
  input logic [2*N-1:0]            p,
  input logic [(STEPS+1)*CW-1:0]   carry_flat
);

  logic [2*N-1:0] ref_prod;
  assign ref_prod = {{N{1'b0}}, a} * {{N{1'b0}}, b};

  always_comb begin
    // R1
    product_match_chk: assert (p == ref_prod)
      else $error("R1 product mismatch");
    // R2
    lsb_vertical_chk: assert (p[0] == (a[0] & b[0]))
      else $error("R2 bit 0 mismatch");
    // R5
    zero_operand_chk: assert (!((a == '0) || (b == '0)) || (p == '0))
      else $error("R5 nonzero product for zero operand");
    // R6
    unit_multiplier_chk: assert (!(b == {{(N-1){1'b0}}, 1'b1}) || (p == {{N{1'b0}}, a}))
      else $error("R6 multiply by one mismatch");
    // R4
    final_carry_chk: assert ((carry_flat[STEPS*CW +: CW] <= 1) &&
                             (carry_flat[STEPS*CW] == p[2*N-1]))
      else $error("R4 final carry wider than one bit");
    // R7
    first_carry_chk: assert (carry_flat[CW-1:0] == '0)
      else $error("R7 carry into column 0");
  end

  if (N >= 2) begin : g_bit1
    always_comb begin
      // R3
      crosswise_bit1_chk: assert (p[1] == ((a[1] & b[0]) ^ (a[0] & b[1])))
        else $error("R3 bit 1 mismatch");
    end
  end

  for (genvar k = 1; k <= STEPS; k++) begin : g_bound
    always_comb begin
      // R7
      no_overflow_chk: assert (int'(carry_flat[k*CW +: CW]) <= N - 1)
        else $error("R7 carry into a column exceeds N-1");
    end
  end

endmodule

bind vc_column_mul vc_column_mul_chk #(.N(N)) u_chk (
  .a          (a),
  .b          (b),
  .p          (p),
  .carry_flat (carry_flat)
);

// File: tb/vc_column_mul_tb.sv
`timescale 1ns/1ps
module vc_column_mul_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;

  vc_column_mul #(.N(4)) u_dut   (.a(a4), .b(b4), .p(p4));
  vc_column_mul #(.N(8)) u_dut8  (.a(a8), .b(b8), .p(p8));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    a4 = x;
    b4 = y;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] swapped;

    // R8: inputs change between edges, sampled 1 ns later with no edge
    apply4(4'd0, 4'd0);
    check(p4 == 8'd0, "R8 settle at zero inputs", p4, 0);

    // R1, R2, R3: exhaustive sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        apply4(i[3:0], j[3:0]);
        check(p4 == 8'(i * j), "R1 exhaustive product", p4, i * j);
        check(p4[0] == (i[0] & j[0]), "R2 bit 0", p4[0], i[0] & j[0]);
        check(p4[1] == ((i[1] & j[0]) ^ (i[0] & j[1])), "R3 bit 1",
              p4[1], (i[1] & j[0]) ^ (i[0] & j[1]));
      end
    end

    // R4, R7: all ones drives the largest carries and the top bit
    apply4(4'hF, 4'hF);
    check(p4 == 8'd225, "R7 max operands no overflow", p4, 225);
    check(p4[7] == 1'b1, "R4 top bit from final carry", p4[7], 1);

    // R5: zero operands
    for (int i = 0; i < 16; i++) begin
      apply4(i[3:0], 4'd0);
      check(p4 == 8'd0, "R5 b zero", p4, 0);
      apply4(4'd0, i[3:0]);
      check(p4 == 8'd0, "R5 a zero", p4, 0);
    end

    // R6: multiplier of one and operand swap
    for (int i = 0; i < 16; i++) begin
      apply4(i[3:0], 4'd1);
      check(p4 == 8'(i), "R6 b equals one", p4, i);
      for (int j = 0; j < 16; j++) begin
        apply4(i[3:0], j[3:0]);
        swapped = p4;
        apply4(j[3:0], i[3:0]);
        check(p4 == swapped, "R6 operand swap", p4, swapped);
      end
    end

    // R9: wider instance, random plus corners
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF; #1;
    check(p8 == 16'd65025, "R9 N=8 all ones", p8, 65025);
    check(p8[15] == 1'b1, "R4 N=8 top bit", p8[15], 1);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      a8 = 8'($urandom);
      b8 = 8'($urandom);
      #1;
      check(p8 == 16'(int'(a8) * int'(b8)), "R9 N=8 random product",
            p8, int'(a8) * int'(b8));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule